// File: doc/BRIEF.md
# Multi-Rate Dot Clock Enable Divider

This block runs on a fast master clock and produces single-cycle dot clock enables for three pixel rates, picked with a two-bit rate select. The master cycles in a scanline are not always a multiple of the dot divisor. The leftover cycles are folded into the first dot period of the line, which is made longer. No short extra period is emitted at the end of the line. As a result, a line always carries exactly `floor(line_len / divisor)` enables.

Two enables come out of one shared line timer.

- **Core enable:** picks up the rate select at every line start. It drives the rendering logic.
- **Scan enable:** uses a rate that is loaded only while frame start is high. A downstream scaler therefore sees one rate for a whole frame.

Both enables fire in the very cycle that opens a line. Rendering work keyed to the enable therefore starts on the same master cycle as the pulse, at every rate. A line opens in one of two ways:

- a falling edge on the active-low horizontal sync input;
- the line counter reaching the programmed line length.

Top module: `dclk_en_div`

## Requirements
- R1: While `rst` is high, both enables are low at the following clock. The line counter restarts at zero. The first cycle after reset is released is a line start, in which both enables are high.
- R2: The rate select encoding gives the divisor. 2'b00 means divide by 8, 2'b01 divide by 6, 2'b10 divide by 4, and 2'b11 divide by 8.
- R3: Each enable pulse lasts one master cycle. No enable is high in two consecutive cycles unless the second cycle is a line start.
- R4: A line starts in the cycle after the clock edge at which `hsync_n` is sampled low, having been high at the edge before. A line also starts in the cycle after the line counter has covered `line_len` cycles. Both enables are high in every line-start cycle.
- R5: With divisor d and r = `line_len` mod d, the first dot period of a line lasts d + r master cycles and every later one lasts d. A 2730-cycle line carries 341, 455 or 682 enables at divisors 8, 6 and 4, never an extra one.
- R6: The core enable takes its rate from `rate_sel` at each line start. A change of `rate_sel` within a line has no effect on the core enable before the next line start.
- R7: The scan rate is loaded from `rate_sel` at every clock edge where `frame_start` is high, and is held otherwise. The scan enable takes that held rate at each line start. When `frame_start` is high at the line-start edge itself, it takes `rate_sel` directly.
- R8: Both enables use the same line start, so their first pulses of a line fall in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| rate_sel | input | 2 | Dot rate select (encoding in R2) |
| line_len | input | LEN_W | Master cycles per line, at least 16 |
| hsync_n | input | 1 | Horizontal sync, active low; its falling edge starts a line |
| frame_start | input | 1 | Loads the scan rate from `rate_sel` while high |
| core_en | output | 1 | Dot enable for the core, rate follows each line start |
| scan_en | output | 1 | Dot enable for the scaler, rate held per frame |

## Verification
The bench builds the block with its default parameters: a 12-bit line length and divisors 8, 6 and 4. It drives the line length as a port, using 2730 cycles to reach the remainder-2, remainder-0 and remainder-2 cases for the three rates, and a 100-cycle line to reach a remainder of 4 and a 16-count line. A behavioural model places enables by line position rather than by period counting. It is compared on every clock while lines are forced by sync edges, wrap on their own, and see rate and frame-start changes in the middle of a line.

// File: rtl/dclk_pkg.sv
package dclk_pkg;

  // Rate select encoding; the alternate code falls back to the slow rate.
  typedef enum logic [1:0] {
    RATE_SLOW = 2'b00,
    RATE_MID  = 2'b01,
    RATE_FAST = 2'b10,
    RATE_ALT  = 2'b11
  } rate_e;

  function automatic int unsigned max3(input int unsigned a,
                                       input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/dclk_line_timer.sv
// Shared scanline timer: sync edge detect, cycle counter and line-start strobe.
module dclk_line_timer #(
  parameter int unsigned LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hsync_n,
  input  logic [LEN_W-1:0] line_len,
  output logic             line_start,  // this edge opens a new line
  output logic             ln_first     // current cycle is line position 0
);

  logic             hs_q;
  logic             fresh_q;
  logic [LEN_W-1:0] cnt_q;
  logic             sync_fall;
  logic             wrap;

  assign sync_fall  = hs_q & ~hsync_n;
  assign wrap       = (cnt_q == line_len - 1'b1);
  assign line_start = sync_fall | fresh_q | wrap;

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_q     <= 1'b1;
      fresh_q  <= 1'b1;
      cnt_q    <= '0;
      ln_first <= 1'b0;
    end else begin
      hs_q     <= hsync_n;
      fresh_q  <= 1'b0;
      ln_first <= line_start;
      if (line_start) cnt_q <= '0;
      else            cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/dclk_rate_hold.sv
// Frame-rate register for the scaler-facing channel.
module dclk_rate_hold (
  input  logic       clk,
  input  logic       rst,
  input  logic       frame_start,
  input  logic [1:0] rate_sel,
  output logic [1:0] held_rate,
  output logic [1:0] eff_rate   // value a line start would capture now
);

  always_ff @(posedge clk) begin
    if (rst)              held_rate <= dclk_pkg::RATE_SLOW;
    else if (frame_start) held_rate <= rate_sel;
  end

  assign eff_rate = frame_start ? rate_sel : held_rate;

endmodule

// File: rtl/dclk_phase_gen.sv
// One enable channel: picks divisor and remainder at line start, then counts periods.
module dclk_phase_gen #(
  parameter int unsigned LEN_W    = 12,
  parameter int unsigned DIV_SLOW = 8,
  parameter int unsigned DIV_MID  = 6,
  parameter int unsigned DIV_FAST = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_start,
  input  logic [1:0]       rate,
  input  logic [LEN_W-1:0] line_len,
  output logic             dot_en
);

  localparam int unsigned DMAX = dclk_pkg::max3(DIV_SLOW, DIV_MID, DIV_FAST);
  localparam int unsigned PW   = $clog2(2 * DMAX);

  logic [PW-1:0] div_sel;
  logic [PW-1:0] rem_sel;
  logic [PW-1:0] rem_slow, rem_mid, rem_fast;
  logic [PW-1:0] div_q;
  logic [PW-1:0] pcnt_q;

  // Constant-divisor remainders, one per rate; the mux then picks one.
  assign rem_slow = PW'(line_len % LEN_W'(DIV_SLOW));
  assign rem_mid  = PW'(line_len % LEN_W'(DIV_MID));
  assign rem_fast = PW'(line_len % LEN_W'(DIV_FAST));

  always_comb begin
    case (dclk_pkg::rate_e'(rate))
      dclk_pkg::RATE_MID:  begin div_sel = PW'(DIV_MID);  rem_sel = rem_mid;  end
      dclk_pkg::RATE_FAST: begin div_sel = PW'(DIV_FAST); rem_sel = rem_fast; end
      default:             begin div_sel = PW'(DIV_SLOW); rem_sel = rem_slow; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dot_en <= 1'b0;
      div_q  <= PW'(DIV_SLOW);
      pcnt_q <= '0;
    end else if (line_start) begin
      // Leftover cycles stretch the first period of the line.
      dot_en <= 1'b1;
      div_q  <= div_sel;
      pcnt_q <= div_sel + rem_sel - 1'b1;
    end else if (pcnt_q == '0) begin
      dot_en <= 1'b1;
      pcnt_q <= div_q - 1'b1;
    end else begin
      dot_en <= 1'b0;
      pcnt_q <= pcnt_q - 1'b1;
    end
  end

endmodule

// File: rtl/dclk_en_div.sv
// Multi-rate dot clock enable divider: core channel and frame-held scan channel.
module dclk_en_div #(
  parameter int unsigned LEN_W    = 12,
  parameter int unsigned DIV_SLOW = 8,
  parameter int unsigned DIV_MID  = 6,
  parameter int unsigned DIV_FAST = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       rate_sel,
  input  logic [LEN_W-1:0] line_len,
  input  logic             hsync_n,
  input  logic             frame_start,
  output logic             core_en,
  output logic             scan_en
);

  localparam int unsigned NCH = 2;  // 0: core, 1: scan

  logic       line_start;
  logic       ln_start;
  logic [1:0] held_rate;
  logic [1:0] eff_rate;
  logic [1:0] ch_rate [NCH];
  logic       ch_en   [NCH];

  dclk_line_timer #(.LEN_W(LEN_W)) timer_i (
    .clk        (clk),
    .rst        (rst),
    .hsync_n    (hsync_n),
    .line_len   (line_len),
    .line_start (line_start),
    .ln_first   (ln_start)
  );

  dclk_rate_hold hold_i (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start),
    .rate_sel    (rate_sel),
    .held_rate   (held_rate),
    .eff_rate    (eff_rate)
  );

  assign ch_rate[0] = rate_sel;
  assign ch_rate[1] = eff_rate;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dclk_phase_gen #(
      .LEN_W    (LEN_W),
      .DIV_SLOW (DIV_SLOW),
      .DIV_MID  (DIV_MID),
      .DIV_FAST (DIV_FAST)
    ) phase_i (
      .clk        (clk),
      .rst        (rst),
      .line_start (line_start),
      .rate       (ch_rate[c]),
      .line_len   (line_len),
      .dot_en     (ch_en[c])
    );
  end

  assign core_en = ch_en[0];
  assign scan_en = ch_en[1];

endmodule

// File: rtl/dclk_en_div_chk.sv
module dclk_en_div_chk (
  input logic       clk,
  input logic       rst,
  input logic       hsync_n,
  input logic       frame_start,
  input logic       core_en,
  input logic       scan_en,
  input logic       ln_start,
  input logic [1:0] held_rate
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!core_en && !scan_en));

  // R3
  core_single_chk: assert property (@(posedge clk) disable iff (rst)
    core_en |=> (!core_en || ln_start));

  // R3
  scan_single_chk: assert property (@(posedge clk) disable iff (rst)
    scan_en |=> (!scan_en || ln_start));

  // R4
  sync_restart_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(hsync_n) |=> (ln_start && core_en));

  // R8
  start_both_chk: assert property (@(posedge clk) disable iff (rst)
    ln_start |-> (core_en && scan_en));

  // R7
  held_rate_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> $stable(held_rate));

endmodule

bind dclk_en_div dclk_en_div_chk chk_i (
  .clk         (clk),
  .rst         (rst),
  .hsync_n     (hsync_n),
  .frame_start (frame_start),
  .core_en     (core_en),
  .scan_en     (scan_en),
  .ln_start    (ln_start),
  .held_rate   (held_rate)
);

// File: tb/dclk_en_div_tb_top.sv
module dclk_en_div_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  rate_sel;
  logic [11:0] line_len;
  logic        hsync_n;
  logic        frame_start;
  logic        core_en, scan_en;

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    done    = 0;
  string tag     = "R1";

  always #4 clk = ~clk;

  dclk_en_div dut_i (
    .clk(clk), .rst(rst), .rate_sel(rate_sel), .line_len(line_len),
    .hsync_n(hsync_n), .frame_start(frame_start),
    .core_en(core_en), .scan_en(scan_en)
  );

  // R2 divisor table
  function automatic int div_of(input logic [1:0] r);
    case (r)
      2'b01:   return 6;
      2'b10:   return 4;
      default: return 8;
    endcase
  endfunction

  // Positional reference model
  int   m_pos = 0, m_cd = 8, m_cr = 0, m_sd = 8, m_sr = 0;
  logic [1:0] m_hold = 2'b00;
  bit   m_hsq = 1, m_fresh = 1;
  bit   exp_core = 0, exp_scan = 0;

  function automatic bit on_grid(input int pos, input int d, input int r);
    if (pos == 0) return 1;
    if (pos < d + r) return 0;
    return ((pos - d - r) % d) == 0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_pos = 0; m_hsq = 1; m_fresh = 1; m_hold = 2'b00;
      exp_core = 0; exp_scan = 0;
    end else begin
      logic [1:0] src;
      bit start;
      start = (m_hsq && !hsync_n) || m_fresh || (m_pos == int'(line_len) - 1);
      src   = frame_start ? rate_sel : m_hold;
      if (start) begin
        m_pos = 0;
        m_cd = div_of(rate_sel); m_cr = int'(line_len) % m_cd;
        m_sd = div_of(src);      m_sr = int'(line_len) % m_sd;
      end else begin
        m_pos = m_pos + 1;
      end
      exp_core = on_grid(m_pos, m_cd, m_cr);
      exp_scan = on_grid(m_pos, m_sd, m_sr);
      if (frame_start) m_hold = rate_sel;
      m_hsq = hsync_n; m_fresh = 0;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      n_tests++;
      if (core_en !== exp_core || scan_en !== exp_scan) begin
        n_fail++;
        $display("FAIL %s model compare: core_en=%0b scan_en=%0b expected %0b %0b at %0t",
                 tag, core_en, scan_en, exp_core, exp_scan, $time);
      end
    end
  end

  task automatic check(input string req, input int act, input int exp, input string what);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Force a line with a sync edge and measure it over len cycles.
  task automatic run_line(input int len, input bit fs_at_start,
                          input int chg_at, input logic [1:0] chg_rate, input bit chg_fs,
                          output int n_core, output int n_scan, output int gap,
                          output int start_ok, output int consec, output int wrap_ok);
    bit prev_c = 0, prev_s = 0;
    n_core = 0; n_scan = 0; gap = -1; start_ok = 0; consec = 0;
    @(negedge clk);
    line_len = 12'(len);
    hsync_n = 1'b0;
    frame_start = fs_at_start;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      frame_start = 1'b0;
      if (i == 0) start_ok = (core_en && scan_en) ? 1 : 0;
      if (core_en) n_core++;
      if (scan_en) n_scan++;
      if (core_en && i > 0 && gap < 0) gap = i;
      if ((core_en && prev_c) || (scan_en && prev_s)) consec++;
      prev_c = core_en; prev_s = scan_en;
      if (i == 3) hsync_n = 1'b1;
      if (i == chg_at) begin
        rate_sel = chg_rate;
        frame_start = chg_fs;
      end
    end
    @(negedge clk);
    wrap_ok = (core_en && scan_en) ? 1 : 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int nc, ns, g, so, cs, wo;
    rst = 1'b1; rate_sel = 2'b00; line_len = 12'd2730;
    hsync_n = 1'b1; frame_start = 1'b0;
    repeat (5) @(negedge clk);
    // R1: quiet during reset
    check("R1", int'(core_en) + int'(scan_en), 0, "enables during reset");
    rst = 1'b0;
    @(negedge clk);
    check("R1", int'(core_en && scan_en), 1, "line start after reset");
    repeat (20) @(negedge clk);

    // R5 slow rate on a 2730-cycle line
    tag = "R5";
    run_line(2730, 1, -1, 2'b00, 0, nc, ns, g, so, cs, wo);
    check("R5", nc, 341, "slow core enables per line");
    check("R5", ns, 341, "slow scan enables per line");
    check("R5", g, 10, "slow stretched first period");
    check("R4", so, 1, "enables at sync-forced line start");
    check("R4", wo, 1, "enables at counter wrap");
    check("R3", cs, 0, "consecutive enables");

    // R2 mid rate
    tag = "R2";
    rate_sel = 2'b01;
    run_line(2730, 1, -1, 2'b01, 0, nc, ns, g, so, cs, wo);
    check("R2", nc, 455, "mid core enables per line");
    check("R2", g, 6, "mid first period");
    check("R8", ns, 455, "mid scan enables per line");

    // R2/R5 fast rate
    rate_sel = 2'b10;
    run_line(2730, 1, -1, 2'b10, 0, nc, ns, g, so, cs, wo);
    check("R5", nc, 682, "fast core enables per line");
    check("R5", g, 6, "fast stretched first period");
    check("R3", cs, 0, "consecutive enables fast");

    // R2 alternate code
    rate_sel = 2'b11;
    run_line(2730, 1, -1, 2'b11, 0, nc, ns, g, so, cs, wo);
    check("R2", nc, 341, "alternate code enables per line");
    check("R2", g, 10, "alternate code first period");

    // R6 mid-line rate change on core channel
    tag = "R6";
    rate_sel = 2'b00;
    run_line(2730, 1, 500, 2'b10, 0, nc, ns, g, so, cs, wo);
    check("R6", nc, 341, "core ignores mid-line rate change");
    // next line: core fast, scan still held slow; frame_start mid-line
    tag = "R7";
    run_line(2730, 0, 300, 2'b10, 1, nc, ns, g, so, cs, wo);
    check("R6", nc, 682, "core rate taken at next line start");
    check("R7", ns, 341, "scan keeps held rate without frame start");
    run_line(2730, 0, -1, 2'b10, 0, nc, ns, g, so, cs, wo);
    check("R7", ns, 682, "scan takes rate loaded by frame start");

    // R5 short line remainders
    tag = "R5";
    rate_sel = 2'b00;
    run_line(100, 1, -1, 2'b00, 0, nc, ns, g, so, cs, wo);
    check("R5", nc, 12, "len100 slow enables");
    check("R5", g, 12, "len100 slow first period");
    check("R4", wo, 1, "short line wrap");
    rate_sel = 2'b01;
    run_line(100, 1, -1, 2'b01, 0, nc, ns, g, so, cs, wo);
    check("R5", nc, 16, "len100 mid enables");
    check("R5", g, 10, "len100 mid first period");
    rate_sel = 2'b10;
    run_line(100, 1, -1, 2'b10, 0, nc, ns, g, so, cs, wo);
    check("R5", nc, 25, "len100 fast enables");
    check("R8", ns, 25, "len100 fast scan enables");

    repeat (4) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule